// File: doc/BRIEF.md
# Page-Walk Rights and Reserved-Field Guard

This block runs beside a multi-level page-table walker. It does not fetch anything on its own. A start pulse opens a walk. The walker then hands over the translation entries one per transfer, and each entry carries its table level and a flag that marks the final step. The guard keeps a running AND of the writable and user flags and a running OR of the execute-disable flag over the entries that count toward the rights. It checks every present entry against the reserved-field rules for that entry's level. When the walk ends, it returns one verdict: allow, or a fault code.

Entries arrive on a valid/ready stream. `ent_ready` is high only while a walk is open and no verdict is waiting, so the walker must hold an entry until it sees ready. The verdict leaves on a second valid/ready stream. `res_valid` and the verdict stay fixed until `res_ready` is seen high at a clock edge. After that the guard goes idle until the next start pulse. A start pulse has priority over everything else: it drops any open walk or pending verdict. The access kind, privilege, write-protect, no-execute and three-level inputs are plain levels. They are sampled with the final entry and must be held steady while a walk is open.

Top module: `pwalk_guard`

## Requirements
- R1: After reset `ent_ready` and `res_valid` are 0. A start pulse opens a walk on the next cycle (`ent_ready`=1, `res_valid`=0), resets writable-all and user-all to 1 and execute-disable-any to 0, and drops any walk or verdict in progress.
- R2: An entry is taken only when `ent_valid` and `ent_ready` are both high. `ent_ready` is never high while `res_valid` is high. The verdict holds until `res_ready`=1 at an edge, and the guard then goes idle. Entries offered while idle or while a verdict is pending are ignored.
- R3: A taken entry with bit 0 (present) clear ends the walk. Code 1 (not present) appears on the next cycle, and no reserved-field check is applied to that entry.
- R4: A present entry at level 3 (top; levels are 3 = top, 2 = pointer table, 1 = directory, 0 = page table) with bit 7 (page size) set ends the walk with code 2 (reserved).
- R5: A present level-1 entry with bit 7 set and any of bits 20..13 set ends the walk with code 2. Bits outside 20..13 never cause this fault.
- R6: With no-execute disabled (`nx_en`=0), a present entry with bit 63 set ends the walk with code 2.
- R7: A reserved-field violation ends the walk at once with code 2, even when the rights would also fail.
- R8: A supervisor read (`acc_kind`=0; value 3 also counts as a read) is allowed whatever the entry flags are.
- R9: A supervisor write (`acc_kind`=1) is allowed when `wp_en`=0. When `wp_en`=1 it needs bit 1 (writable) set in every counted entry, or the code is 3 (rights).
- R10: A supervisor fetch (`acc_kind`=2) is allowed when `nx_en`=0. When `nx_en`=1 it needs bit 63 clear in every counted entry, or the code is 3.
- R11: A user-mode access also needs bit 2 (user) set in every counted entry. A user write always needs writable-all, whatever `wp_en` is. Failing either gives code 3.
- R12: With `three_lvl`=1, level-2 entries are still checked for reserved fields but are not counted for writable, user or execute-disable.
- R13: The verdict is registered. It appears on the cycle after the final entry is taken, with code 0 (none) when allowed, and `res_allow` is 1 exactly when the code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a new walk and clears the accumulators |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| user_mode | input | 1 | 1 = user privilege |
| wp_en | input | 1 | Supervisor write-protect enable |
| nx_en | input | 1 | No-execute enable |
| three_lvl | input | 1 | Three-level mode: level-2 entries do not count toward rights |
| ent_valid | input | 1 | Entry offered |
| ent_ready | output | 1 | Entry can be taken |
| ent_data | input | 64 | Translation entry |
| ent_level | input | 2 | Table level of the entry |
| ent_last | input | 1 | Entry is the final step |
| res_valid | output | 1 | Verdict available |
| res_ready | input | 1 | Verdict accepted |
| res_fault | output | 2 | 0 none, 1 not present, 2 reserved, 3 rights |
| res_allow | output | 1 | Access allowed |

## Verification
Two situations are hard to reach from the ports. The first is a walk whose rights fail through an early entry while its final entry breaks a reserved-field rule. To reach it, the stimulus builds a non-writable walk and ends it on a malformed directory entry. The second is three-level mode: there the same bad pointer-table entry must change the verdict in one mode and leave it unchanged in the other, so the stimulus repeats an identical walk with only `three_lvl` flipped. Back-pressure is reached by dropping `res_ready` and offering entries while the verdict waits. A behavioural model in the bench predicts every output on every cycle.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_RSVD   = 2'd2,
    FLT_RIGHTS = 2'd3
  } pwg_fault_e;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_FX  = 2'd2,
    ACC_RD2 = 2'd3
  } pwg_acc_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_DONE = 2'd2
  } pwg_state_e;
endpackage

// File: rtl/pwg_rsvd_check.sv
module pwg_rsvd_check #(
  parameter int ENTRY_W = 64,
  parameter int LVL_W   = 2,
  parameter int TOP_LVL = 3,
  parameter int DIR_LVL = 1,
  parameter int PS_BIT  = 7,
  parameter int XD_BIT  = 63,
  parameter int RSV_LO  = 13,
  parameter int RSV_HI  = 20
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic [LVL_W-1:0]   level,
  input  logic               nx_en,
  output logic               rsvd_hit
);
  localparam int RSV_N = RSV_HI - RSV_LO + 1;

  logic [RSV_N-1:0] field;
  logic top_ps, dir_field, xd_rsvd;

  for (genvar i = 0; i < RSV_N; i++) begin : g_field
    assign field[i] = entry[RSV_LO + i];
  end

  always_comb begin
    top_ps    = (level == LVL_W'(TOP_LVL)) && entry[PS_BIT];
    dir_field = (level == LVL_W'(DIR_LVL)) && entry[PS_BIT] && (|field);
    xd_rsvd   = !nx_en && entry[XD_BIT];
    rsvd_hit  = top_ps || dir_field || xd_rsvd;
  end
endmodule

// File: rtl/pwg_rights_acc.sv
module pwg_rights_acc #(
  parameter int ENTRY_W = 64,
  parameter int RW_BIT  = 1,
  parameter int US_BIT  = 2,
  parameter int XD_BIT  = 63
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               upd,
  input  logic [ENTRY_W-1:0] entry,
  output logic               nxt_wr_all,
  output logic               nxt_us_all,
  output logic               nxt_xd_any
);
  logic wr_all_q, us_all_q, xd_any_q;

  always_comb begin
    nxt_wr_all = wr_all_q;
    nxt_us_all = us_all_q;
    nxt_xd_any = xd_any_q;
    if (upd) begin
      nxt_wr_all = wr_all_q && entry[RW_BIT];
      nxt_us_all = us_all_q && entry[US_BIT];
      nxt_xd_any = xd_any_q || entry[XD_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_all_q <= 1'b1;
      us_all_q <= 1'b1;
      xd_any_q <= 1'b0;
    end else if (upd) begin
      wr_all_q <= nxt_wr_all;
      us_all_q <= nxt_us_all;
      xd_any_q <= nxt_xd_any;
    end
  end
endmodule

// File: rtl/pwg_decide.sv
module pwg_decide
  import pwg_pkg::*;
(
  input  logic [1:0] acc_kind,
  input  logic       user_mode,
  input  logic       wp_en,
  input  logic       nx_en,
  input  logic       wr_all,
  input  logic       us_all,
  input  logic       xd_any,
  output logic       rights_ok
);
  pwg_acc_e kind;

  always_comb begin
    kind = pwg_acc_e'(acc_kind);
    unique case (kind)
      ACC_WR:  rights_ok = (user_mode || wp_en) ? wr_all : 1'b1;
      ACC_FX:  rights_ok = nx_en ? !xd_any : 1'b1;
      default: rights_ok = 1'b1;
    endcase
    if (user_mode && !us_all) rights_ok = 1'b0;
  end
endmodule

// File: rtl/pwalk_guard.sv
module pwalk_guard
  import pwg_pkg::*;
#(
  parameter int ENTRY_W = 64,
  parameter int LVL_W   = 2,
  parameter int P_BIT   = 0,
  parameter int RW_BIT  = 1,
  parameter int US_BIT  = 2,
  parameter int PS_BIT  = 7,
  parameter int RSV_LO  = 13,
  parameter int RSV_HI  = 20,
  parameter int TOP_LVL = 3,
  parameter int PTR_LVL = 2,
  parameter int DIR_LVL = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         acc_kind,
  input  logic               user_mode,
  input  logic               wp_en,
  input  logic               nx_en,
  input  logic               three_lvl,
  input  logic               ent_valid,
  output logic               ent_ready,
  input  logic [ENTRY_W-1:0] ent_data,
  input  logic [LVL_W-1:0]   ent_level,
  input  logic               ent_last,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [1:0]         res_fault,
  output logic               res_allow
);
  localparam int XD_BIT = ENTRY_W - 1;

  pwg_state_e st_q, st_d;
  pwg_fault_e flt_q, flt_d;
  logic       allow_q, allow_d;
  logic       take, present, rsvd_hit, skip_rights, upd;
  logic       wr_all, us_all, xd_any, rights_ok;

  assign take        = ent_valid && ent_ready && !start;
  assign present     = ent_data[P_BIT];
  assign skip_rights = three_lvl && (ent_level == LVL_W'(PTR_LVL));
  assign upd         = take && present && !rsvd_hit && !skip_rights;

  pwg_rsvd_check #(
    .ENTRY_W(ENTRY_W), .LVL_W(LVL_W), .TOP_LVL(TOP_LVL), .DIR_LVL(DIR_LVL),
    .PS_BIT(PS_BIT), .XD_BIT(XD_BIT), .RSV_LO(RSV_LO), .RSV_HI(RSV_HI)
  ) u_rsvd (
    .entry(ent_data), .level(ent_level), .nx_en(nx_en), .rsvd_hit(rsvd_hit)
  );

  pwg_rights_acc #(
    .ENTRY_W(ENTRY_W), .RW_BIT(RW_BIT), .US_BIT(US_BIT), .XD_BIT(XD_BIT)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(start), .upd(upd), .entry(ent_data),
    .nxt_wr_all(wr_all), .nxt_us_all(us_all), .nxt_xd_any(xd_any)
  );

  pwg_decide u_dec (
    .acc_kind(acc_kind), .user_mode(user_mode), .wp_en(wp_en), .nx_en(nx_en),
    .wr_all(wr_all), .us_all(us_all), .xd_any(xd_any), .rights_ok(rights_ok)
  );

  always_comb begin
    st_d    = st_q;
    flt_d   = flt_q;
    allow_d = allow_q;
    if (start) begin
      st_d    = ST_WALK;
      flt_d   = FLT_NONE;
      allow_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_WALK: begin
          if (take) begin
            if (!present) begin
              st_d = ST_DONE; flt_d = FLT_ABSENT; allow_d = 1'b0;
            end else if (rsvd_hit) begin
              st_d = ST_DONE; flt_d = FLT_RSVD; allow_d = 1'b0;
            end else if (ent_last) begin
              st_d    = ST_DONE;
              flt_d   = rights_ok ? FLT_NONE : FLT_RIGHTS;
              allow_d = rights_ok;
            end
          end
        end
        ST_DONE: begin
          if (res_ready) begin
            st_d    = ST_IDLE;
            allow_d = 1'b0;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      flt_q   <= FLT_NONE;
      allow_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      flt_q   <= flt_d;
      allow_q <= allow_d;
    end
  end

  assign ent_ready = (st_q == ST_WALK);
  assign res_valid = (st_q == ST_DONE);
  assign res_fault = flt_q;
  assign res_allow = allow_q && res_valid;
endmodule

// File: rtl/pwg_guard_chk.sv
module pwg_guard_chk #(
  parameter int ENTRY_W = 64,
  parameter int LVL_W   = 2,
  parameter int P_BIT   = 0,
  parameter int PS_BIT  = 7,
  parameter int TOP_LVL = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               ent_valid,
  input logic               ent_ready,
  input logic [ENTRY_W-1:0] ent_data,
  input logic [LVL_W-1:0]   ent_level,
  input logic               res_valid,
  input logic               res_ready,
  input logic [1:0]         res_fault,
  input logic               res_allow
);
  logic taken;
  assign taken = ent_valid && ent_ready && !start;

  a_r2_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ent_ready && res_valid));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready && !start |=> res_valid && $stable(res_fault) && $stable(res_allow));

  a_r1_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ent_ready && !res_valid);

  a_r3_absent: assert property (@(posedge clk) disable iff (!rst_n)
    taken && !ent_data[P_BIT] |=> res_valid && res_fault == 2'd1);

  a_r4_top_ps: assert property (@(posedge clk) disable iff (!rst_n)
    taken && ent_data[P_BIT] && ent_data[PS_BIT] && ent_level == LVL_W'(TOP_LVL)
    |=> res_valid && res_fault == 2'd2);

  a_r13_allow_code: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_allow == (res_fault == 2'd0)));
endmodule

bind pwalk_guard pwg_guard_chk #(
  .ENTRY_W(ENTRY_W), .LVL_W(LVL_W), .P_BIT(P_BIT), .PS_BIT(PS_BIT), .TOP_LVL(TOP_LVL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ent_valid(ent_valid),
  .ent_ready(ent_ready), .ent_data(ent_data), .ent_level(ent_level),
  .res_valid(res_valid), .res_ready(res_ready), .res_fault(res_fault),
  .res_allow(res_allow)
);

// File: tb/sim_pwalk_guard.sv
module sim_pwalk_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  acc_kind = 2'd0;
  logic        user_mode = 1'b0, wp_en = 1'b0, nx_en = 1'b0, three_lvl = 1'b0;
  logic        ent_valid = 1'b0;
  logic        ent_ready;
  logic [63:0] ent_data = '0;
  logic [1:0]  ent_level = 2'd0;
  logic        ent_last = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [1:0]  res_fault;
  logic        res_allow;

  always #2 clk = ~clk;

  pwalk_guard u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .acc_kind(acc_kind),
    .user_mode(user_mode), .wp_en(wp_en), .nx_en(nx_en), .three_lvl(three_lvl),
    .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_data(ent_data),
    .ent_level(ent_level), .ent_last(ent_last), .res_valid(res_valid),
    .res_ready(res_ready), .res_fault(res_fault), .res_allow(res_allow)
  );

  int    checks = 0;
  int    fails = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_walk = 0, m_pend = 0;
  int m_fault = 0;
  bit m_wr = 1, m_us = 1, m_xd = 0;

  function automatic bit [63:0] mk(bit p, bit rw, bit us, bit ps, bit xd, int extra);
    bit [63:0] e = '0;
    e[0] = p; e[1] = rw; e[2] = us; e[7] = ps; e[63] = xd;
    if (extra >= 0) e[extra] = 1'b1;
    return e;
  endfunction

  function automatic bit model_rights(int kind, bit usr, bit wp, bit nx, bit wr, bit us, bit xd);
    if (usr && !us) return 0;
    if (kind == 1) begin
      if (usr) return wr;
      if (wp) return wr;
      return 1;
    end
    if (kind == 2) begin
      if (nx && xd) return 0;
      return 1;
    end
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_walk = 0; m_pend = 0; m_fault = 0; m_wr = 1; m_us = 1; m_xd = 0;
    end else if (start) begin
      m_walk = 1; m_pend = 0; m_wr = 1; m_us = 1; m_xd = 0;
    end else if (m_pend) begin
      if (res_ready) m_pend = 0;
    end else if (m_walk && ent_valid) begin
      bit rsv;
      rsv = 0;
      if (ent_level == 2'd3 && ent_data[7]) rsv = 1;
      if (ent_level == 2'd1 && ent_data[7] && ent_data[20:13] != 0) rsv = 1;
      if (!nx_en && ent_data[63]) rsv = 1;
      if (!ent_data[0]) begin
        m_fault = 1; m_pend = 1; m_walk = 0;
      end else if (rsv) begin
        m_fault = 2; m_pend = 1; m_walk = 0;
      end else begin
        if (!(three_lvl && ent_level == 2'd2)) begin
          m_wr = m_wr & ent_data[1];
          m_us = m_us & ent_data[2];
          m_xd = m_xd | ent_data[63];
        end
        if (ent_last) begin
          m_fault = model_rights(int'(acc_kind), user_mode, wp_en, nx_en, m_wr, m_us, m_xd) ? 0 : 3;
          m_pend = 1; m_walk = 0;
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      checks++;
      if (res_valid !== m_pend || ent_ready !== m_walk ||
          (m_pend && (res_fault !== 2'(m_fault) || res_allow !== (m_fault == 0)))) begin
        fails++;
        $display("FAIL %s model: got v=%0d r=%0d f=%0d a=%0d expected v=%0d r=%0d f=%0d a=%0d",
                 cur_req, res_valid, ent_ready, res_fault, res_allow,
                 m_pend, m_walk, m_fault, (m_fault == 0));
      end
    end
  end

  task automatic chk(string r, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", r, got, exp);
    end
  endtask

  task automatic go(bit [1:0] a, bit u, bit wp, bit nx, bit th);
    @(negedge clk);
    acc_kind = a; user_mode = u; wp_en = wp; nx_en = nx; three_lvl = th; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic send(bit [63:0] d, bit [1:0] l, bit last);
    @(negedge clk);
    ent_data = d; ent_level = l; ent_last = last; ent_valid = 1;
    @(posedge clk);
    #1;
    ent_valid = 0;
  endtask

  task automatic expect_res(string r, int f);
    chk(r, {res_valid, res_fault, res_allow}, {1'b1, 2'(f), (f == 0)});
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1 reset ready", ent_ready, 0);
    chk("R1 reset valid", res_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after reset", ent_ready, 0);

    // R8 / R13: supervisor read, non-writable walk
    cur_req = "R8";
    go(2'd0, 0, 1, 1, 0);
    chk("R1 start opens walk", ent_ready, 1);
    send(mk(1,0,0,0,0,-1), 2'd3, 0);
    send(mk(1,0,0,0,0,-1), 2'd2, 0);
    send(mk(1,0,0,0,0,-1), 2'd1, 0);
    send(mk(1,0,0,0,0,-1), 2'd0, 1);
    expect_res("R8 supervisor read allowed", 0);
    chk("R13 allow flag", res_allow, 1);

    // R9 write protect
    cur_req = "R9";
    go(2'd1, 0, 1, 1, 0);
    send(mk(1,1,0,0,0,-1), 2'd3, 0);
    send(mk(1,0,0,0,0,-1), 2'd0, 1);
    expect_res("R9 wp on, read-only entry", 3);
    go(2'd1, 0, 0, 1, 0);
    send(mk(1,1,0,0,0,-1), 2'd3, 0);
    send(mk(1,0,0,0,0,-1), 2'd0, 1);
    expect_res("R9 wp off", 0);

    // R10 no-execute
    cur_req = "R10";
    go(2'd2, 0, 0, 1, 0);
    send(mk(1,1,1,0,1,-1), 2'd3, 0);
    send(mk(1,1,1,0,0,-1), 2'd0, 1);
    expect_res("R10 nx on, xd set", 3);
    go(2'd2, 0, 0, 0, 0);
    send(mk(1,1,1,0,0,-1), 2'd3, 0);
    send(mk(1,1,1,0,0,-1), 2'd0, 1);
    expect_res("R10 nx off", 0);

    // R6 bit 63 reserved when nx off
    cur_req = "R6";
    go(2'd0, 0, 0, 0, 0);
    send(mk(1,1,1,0,1,-1), 2'd1, 0);
    expect_res("R6 bit63 reserved", 2);

    // R3 non-present, no reserved check
    cur_req = "R3";
    go(2'd0, 0, 0, 0, 0);
    send(mk(1,1,1,0,0,-1), 2'd3, 0);
    send(mk(0,1,1,1,1,15), 2'd1, 0);
    expect_res("R3 not present", 1);
    chk("R3 walk ended", ent_ready, 0);

    // R4 top-level page size
    cur_req = "R4";
    go(2'd0, 0, 0, 1, 0);
    send(mk(1,1,1,1,0,-1), 2'd3, 0);
    expect_res("R4 top ps reserved", 2);

    // R5 directory field
    cur_req = "R5";
    go(2'd0, 0, 0, 1, 0);
    send(mk(1,1,1,0,0,-1), 2'd3, 0);
    send(mk(1,1,1,0,0,-1), 2'd2, 0);
    send(mk(1,1,1,1,0,15), 2'd1, 1);
    expect_res("R5 dir bit15 reserved", 2);
    go(2'd0, 0, 0, 1, 0);
    send(mk(1,1,1,0,0,12), 2'd3, 0);
    send(mk(1,1,1,1,0,21), 2'd1, 1);
    expect_res("R5 bit21 not reserved", 0);
    go(2'd0, 0, 0, 1, 0);
    send(mk(1,1,1,1,0,12), 2'd1, 1);
    expect_res("R5 bit12 not reserved", 0);

    // R7 reserved over rights
    cur_req = "R7";
    go(2'd1, 0, 1, 1, 0);
    send(mk(1,0,1,0,0,-1), 2'd3, 0);
    send(mk(1,0,1,0,0,-1), 2'd2, 0);
    send(mk(1,0,1,1,0,20), 2'd1, 1);
    expect_res("R7 reserved beats rights", 2);

    // R11 user mode
    cur_req = "R11";
    go(2'd0, 1, 0, 1, 0);
    send(mk(1,1,1,0,0,-1), 2'd3, 0);
    send(mk(1,1,0,0,0,-1), 2'd0, 1);
    expect_res("R11 user read, us clear", 3);
    go(2'd1, 1, 0, 1, 0);
    send(mk(1,0,1,0,0,-1), 2'd3, 0);
    send(mk(1,1,1,0,0,-1), 2'd0, 1);
    expect_res("R11 user write wp off", 3);
    go(2'd1, 1, 0, 1, 0);
    send(mk(1,1,1,0,0,-1), 2'd3, 0);
    send(mk(1,1,1,0,0,-1), 2'd0, 1);
    expect_res("R11 user write ok", 0);

    // R12 three-level mode
    cur_req = "R12";
    go(2'd1, 1, 1, 1, 1);
    send(mk(1,0,0,0,1,-1), 2'd2, 0);
    send(mk(1,1,1,0,0,-1), 2'd1, 0);
    send(mk(1,1,1,0,0,-1), 2'd0, 1);
    expect_res("R12 pointer entry not counted", 0);
    go(2'd1, 1, 1, 1, 0);
    send(mk(1,0,0,0,1,-1), 2'd2, 0);
    send(mk(1,1,1,0,0,-1), 2'd1, 0);
    send(mk(1,1,1,0,0,-1), 2'd0, 1);
    expect_res("R12 counted in four-level", 3);
    go(2'd0, 0, 0, 0, 1);
    send(mk(1,1,1,0,1,-1), 2'd2, 1);
    expect_res("R12 reserved still checked", 2);

    // R2 back-pressure
    cur_req = "R2";
    go(2'd0, 0, 0, 1, 0);
    @(negedge clk);
    res_ready = 0;
    send(mk(1,1,1,0,0,-1), 2'd0, 1);
    expect_res("R2 verdict", 0);
    @(negedge clk);
    ent_data = mk(0,0,0,0,0,-1); ent_valid = 1; ent_last = 1;
    repeat (3) @(negedge clk);
    ent_valid = 0;
    expect_res("R2 held under back-pressure", 0);
    chk("R2 ready low while pending", ent_ready, 0);
    res_ready = 1;
    @(negedge clk);
    chk("R2 consumed", res_valid, 0);
    ent_data = mk(0,0,0,0,0,-1); ent_valid = 1;
    @(negedge clk);
    ent_valid = 0;
    chk("R2 idle ignores entry", res_valid, 0);

    // R1 restart mid-walk clears accumulators
    cur_req = "R1";
    go(2'd1, 0, 1, 1, 0);
    send(mk(1,0,1,0,0,-1), 2'd3, 0);
    go(2'd1, 0, 1, 1, 0);
    send(mk(1,1,1,0,0,-1), 2'd0, 1);
    expect_res("R1 restart clears", 0);
    cur_req = "R13";
    go(2'd0, 0, 0, 1, 0);
    send(mk(1,1,1,0,0,-1), 2'd3, 0);
    chk("R13 no verdict before last", res_valid, 0);
    send(mk(1,1,1,0,0,-1), 2'd0, 1);
    expect_res("R13 verdict next cycle", 0);

    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule